// File: doc/BRIEF.md
# SPI DAC Command Frame Transmitter

This block is a write-only SPI master that delivers one 16-bit command word to a serial digital-to-analog converter for each accepted request. The word has two parts. A 4-bit configuration header comes first and holds the channel choice, the reference-buffer control, the gain choice and the output-enable control. A 12-bit conversion value follows it. The converter returns nothing, so the block has no serial input. It drives only chip select, the serial clock and the serial data line.

On the system side the block uses a start/busy/done handshake. When the block is idle, a start request latches the configuration inputs, the value and the clock divider setting, and a frame begins. Each half period of the serial clock lasts a programmable number of system clocks. After the last bit, chip select returns high and done pulses once. The block then holds chip select high for one more full serial clock period before it accepts the next request.

Top module: `dac_frame_tx`

## Requirements
- R1: The frame is 16 bits. Bits are sent MSB first, and bits 11:0 of the frame carry `value_i`, most significant bit first, after the header.
- R2: The header occupies frame bits 15:12. Bit 15 is `ch_b_i` (1 = channel B). Bit 14 is `buf_en_i`. Bit 13 is the inverse of `gain_x2_i` (0 selects the higher gain). Bit 12 is `out_en_i` (0 shuts the output down).
- R3: The serial clock uses mode 0. `sck_o` is low while chip select is high and at idle. `sdo_o` changes only while `sck_o` is low, so it is stable for every cycle that `sck_o` is high.
- R4: Each frame has exactly 16 rising edges of `sck_o` while `cs_n_o` is low.
- R5: Every half period of `sck_o` lasts `div_i`+1 system clocks. There is one low lead-in half before the first rising edge and one low trailing half after the last falling edge.
- R6: `cs_n_o` falls in the cycle after the start is accepted. It rises at the end of the trailing low half, and it then stays high for at least 2·(`div_i`+1) cycles before the next frame can begin.
- R7: `busy_o` is high from the cycle after acceptance until the end of the chip-select-high guard. A start request while `busy_o` is high is ignored.
- R8: `done_o` is high for exactly one system clock, in the cycle in which `cs_n_o` returns high.
- R9: While in reset and after reset, `cs_n_o`=1, `sck_o`=0, `sdo_o`=0, `busy_o`=0 and `done_o`=0.
- R10: The header inputs, `value_i` and `div_i` are sampled only at acceptance. Changes to them during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame request, taken when idle |
| ch_b_i | input | 1 | 1 selects output channel B |
| buf_en_i | input | 1 | Reference buffer enable |
| gain_x2_i | input | 1 | 1 selects the higher gain |
| out_en_i | input | 1 | 0 shuts the output down |
| value_i | input | 12 | Conversion value |
| div_i | input | DIV_W | SCK half period minus one, in system clocks |
| busy_o | output | 1 | Frame or guard in progress |
| done_o | output | 1 | One-cycle pulse when chip select rises |
| cs_n_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data to converter |

## Verification
Let H be `div_i`+1, taken at the accepting edge, and count t from the first cycle after that edge. Then chip select is low and data carries bit 15 at t=0. Serial clock half k covers cycles kH to kH+H−1. Chip select and done rise at t=33H, and busy drops after t=35H−1. The bench reference model advances t on every rising edge and derives every expected output from t and H. The outputs are sampled on the falling edge, so each comparison sees the registers after the edge that was due to update them. The bench also reassembles the word bit by bit from the rising serial clock edges, and checks it and the edge count when chip select rises.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;
  localparam int HDR_W = 4;
  localparam int VAL_W = 12;
  localparam int FRAME_W = HDR_W + VAL_W;

  typedef struct packed {
    logic ch_b;
    logic buf_en;
    logic gain_x2;
    logic out_en;
  } dac_cfg_t;

  typedef enum logic {
    ST_IDLE,
    ST_RUN
  } tx_state_e;
endpackage

// File: rtl/dac_frame_pack.sv
module dac_frame_pack
  import dac_tx_pkg::*;
(
  input  dac_cfg_t           cfg_i,
  input  logic [VAL_W-1:0]   value_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [HDR_W-1:0] hdr;

  // gain bit active low: 0 selects the higher gain
  assign hdr = {cfg_i.ch_b, cfg_i.buf_en, ~cfg_i.gain_x2, cfg_i.out_en};
  assign frame_o = {hdr, value_i};
endmodule

// File: rtl/dac_half_timer.sv
module dac_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] lim_i,
  input  logic             run_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] lim_q;
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == lim_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      lim_q <= lim_i;
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dac_tx_seq.sv
module dac_tx_seq
  import dac_tx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               tick_i,
  output logic               accept_o,
  output logic               busy_o,
  output logic               cs_n_o,
  output logic               sck_o,
  output logic               sdo_o,
  output logic               done_o
);
  // halves: 0 lead-in, 1..HALF_DATA data, then two guard halves
  localparam int HALF_DATA = 2 * FRAME_W;
  localparam int HALF_LAST = HALF_DATA + 2;
  localparam int HS_W = $clog2(HALF_LAST + 1);

  tx_state_e          state_q;
  logic [HS_W-1:0]    half_q;
  logic [HS_W-1:0]    half_nxt;
  logic [FRAME_W-1:0] shreg_q;
  logic               cs_n_q;
  logic               sck_q;
  logic               done_q;

  assign half_nxt = half_q + 1'b1;
  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign busy_o   = (state_q == ST_RUN);
  assign cs_n_o   = cs_n_q;
  assign sck_o    = sck_q;
  assign sdo_o    = shreg_q[FRAME_W-1] & ~cs_n_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      half_q  <= '0;
      shreg_q <= '0;
      cs_n_q  <= 1'b1;
      sck_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            half_q  <= '0;
            shreg_q <= frame_i;
            cs_n_q  <= 1'b0;
            sck_q   <= 1'b0;
          end
        end
        ST_RUN: begin
          if (tick_i) begin
            if (half_q == HS_W'(HALF_LAST)) begin
              state_q <= ST_IDLE;
            end else begin
              half_q <= half_nxt;
              if (half_nxt <= HS_W'(HALF_DATA)) begin
                sck_q <= half_nxt[0];
                // falling edge: next bit, except after the last one
                if (!half_nxt[0] && (half_nxt != HS_W'(HALF_DATA)))
                  shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
              end else if (half_nxt == HS_W'(HALF_DATA + 1)) begin
                cs_n_q <= 1'b1;
                done_q <= 1'b1;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx
  import dac_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ch_b_i,
  input  logic             buf_en_i,
  input  logic             gain_x2_i,
  input  logic             out_en_i,
  input  logic [11:0]      value_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             cs_n_o,
  output logic             sck_o,
  output logic             sdo_o
);
  dac_cfg_t           cfg;
  logic [FRAME_W-1:0] frame;
  logic               accept;
  logic               tick;

  assign cfg = '{ch_b: ch_b_i, buf_en: buf_en_i, gain_x2: gain_x2_i, out_en: out_en_i};

  dac_frame_pack i_pack (
    .cfg_i   (cfg),
    .value_i (value_i),
    .frame_o (frame)
  );

  dac_half_timer #(.DIV_W(DIV_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .lim_i  (div_i),
    .run_i  (busy_o),
    .tick_o (tick)
  );

  dac_tx_seq i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .frame_i  (frame),
    .tick_i   (tick),
    .accept_o (accept),
    .busy_o   (busy_o),
    .cs_n_o   (cs_n_o),
    .sck_o    (sck_o),
    .sdo_o    (sdo_o),
    .done_o   (done_o)
  );
endmodule

// File: rtl/dac_frame_tx_chk.sv
module dac_frame_tx_chk
  import dac_tx_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic cs_n_o,
  input logic sck_o,
  input logic sdo_o
);
  logic       sck_q;
  logic [5:0] rise_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q    <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sck_q <= sck_o;
      if (cs_n_o) rise_cnt <= '0;
      else if (sck_o && !sck_q) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  p_sck_low_cs_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sck_o);

  p_sdo_stable_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> $stable(sdo_o));

  p_sixteen_rises_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |-> (rise_cnt == 6'(FRAME_W)));

  p_cs_fall_from_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> $rose(busy_o));

  p_busy_end_cs_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (cs_n_o && $past(cs_n_o)));

  p_done_at_cs_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($rose(cs_n_o) && busy_o));

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind dac_frame_tx dac_frame_tx_chk i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_o (busy_o),
  .done_o (done_o),
  .cs_n_o (cs_n_o),
  .sck_o  (sck_o),
  .sdo_o  (sdo_o)
);

// File: tb/test_dac_frame_tx.sv
module test_dac_frame_tx;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, ch_b = 1'b0, buf_en = 1'b0, gain_x2 = 1'b0, out_en = 1'b0;
  logic [11:0] value = '0;
  logic [DIV_W-1:0] div = '0;
  logic busy, done, cs_n, sck, sdo;

  always #4 clk = ~clk;

  dac_frame_tx #(.DIV_W(DIV_W)) i_dac_frame_tx (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ch_b_i(ch_b), .buf_en_i(buf_en),
    .gain_x2_i(gain_x2), .out_en_i(out_en), .value_i(value), .div_i(div),
    .busy_o(busy), .done_o(done), .cs_n_o(cs_n), .sck_o(sck), .sdo_o(sdo)
  );

  int checks = 0, fails = 0;
  bit fin = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // R2: header bit15 ch, bit14 buf, bit13 ~gain, bit12 out_en; R1: value in 11:0
  function automatic logic [15:0] mk_word(logic c, logic b, logic g, logic e, logic [11:0] v);
    return {c, b, ~g, e, v};
  endfunction

  // reference model
  bit m_busy = 0;
  int t = 0, hh = 1, n_acc = 0;
  logic [15:0] m_word = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; t = 0;
    end else if (m_busy) begin
      if (t == 35 * hh - 1) m_busy = 0;
      else t++;
    end else if (start) begin
      m_busy = 1; t = 0; hh = int'(div) + 1;
      m_word = mk_word(ch_b, buf_en, gain_x2, out_en, value);
      n_acc++;
    end
  end

  // per-cycle comparison and bit capture on the falling edge
  logic p_sck = 0, p_sdo = 0, p_cs = 1;
  logic [15:0] cap = '0;
  int edges = 0, n_cs_fall = 0;

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      automatic bit e_cs = 1, e_sck = 0, e_sdo = 0, e_done = 0, e_busy = 0;
      if (m_busy) begin
        automatic int k = t / hh;
        automatic int idx = (k / 2 > 15) ? 15 : k / 2;
        e_busy = 1;
        e_cs = (k >= 33);
        e_sck = (k >= 1 && k <= 32 && (k % 2 == 1));
        e_sdo = e_cs ? 1'b0 : m_word[15 - idx];
        e_done = (k == 33 && (t % hh == 0));
      end
      chk(cs_n === e_cs, "R6 cs_n", 32'(cs_n), 32'(e_cs));
      chk(sck === e_sck, "R5 sck", 32'(sck), 32'(e_sck));
      chk(sdo === e_sdo, "R1 sdo", 32'(sdo), 32'(e_sdo));
      chk(busy === e_busy, "R7 busy", 32'(busy), 32'(e_busy));
      chk(done === e_done, "R8 done", 32'(done), 32'(e_done));
      if (sck) chk(sdo === p_sdo, "R3 sdo stable while sck high", 32'(sdo), 32'(p_sdo));
      if (cs_n) chk(!sck, "R3 sck low while cs high", 32'(sck), 0);
      if (sck && !p_sck) begin
        cap = {cap[14:0], sdo};
        edges++;
      end
      if (!cs_n && p_cs) begin
        n_cs_fall++;
        edges = 0;
      end
      if (cs_n && !p_cs) begin
        chk(edges == 16, "R4 rising edges per frame", edges, 16);
        chk(cap[15:12] === m_word[15:12], "R2 header", cap[15:12], m_word[15:12]);
        chk(cap[11:0] === m_word[11:0], "R1/R10 value", cap[11:0], m_word[11:0]);
      end
      p_sck = sck; p_sdo = sdo; p_cs = cs_n;
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic send(input logic c, b, g, e, input logic [11:0] v, input logic [DIV_W-1:0] d);
    @(negedge clk);
    ch_b = c; buf_en = b; gain_x2 = g; out_en = e; value = v; div = d; start = 1;
    @(negedge clk);
    start = 0;
    wait_idle();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 during reset
    chk(cs_n === 1 && sck === 0 && sdo === 0 && busy === 0 && done === 0, "R9 reset outputs",
        {cs_n, sck, sdo, busy, done}, 5'b10000);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(cs_n === 1 && sck === 0 && sdo === 0 && busy === 0 && done === 0, "R9 idle after reset",
        {cs_n, sck, sdo, busy, done}, 5'b10000);

    send(0, 0, 0, 1, 12'hA5C, 0);
    send(1, 1, 1, 0, 12'hFFF, 3);
    send(0, 1, 0, 0, 12'h000, 1);
    send(1, 0, 1, 1, 12'h801, 2);

    // R10 and R7: inputs change and start repeats mid-frame
    @(negedge clk);
    ch_b = 1; buf_en = 0; gain_x2 = 0; out_en = 1; value = 12'h3C6; div = 2; start = 1;
    @(negedge clk);
    start = 0;
    repeat (10) @(negedge clk);
    ch_b = 0; buf_en = 1; gain_x2 = 1; out_en = 0; value = 12'h5A5; div = 0;
    start = 1;
    repeat (3) @(negedge clk);
    start = 0;
    repeat (40) @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    wait_idle();

    // back-to-back: start held high across two frames
    @(negedge clk);
    value = 12'h7E1; div = 1; start = 1;
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    value = 12'h1B3;
    while (!busy) @(negedge clk);
    start = 0;
    wait_idle();
    repeat (4) @(negedge clk);

    chk(n_cs_fall == n_acc, "R7 one frame per accepted start", n_cs_fall, n_acc);
    chk(n_acc == 7, "R7 ignored starts while busy", n_acc, 7);
    fin = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      checks++; fails++;
      $display("FAIL R7 watchdog expired actual=busy expected=idle");
      summary();
      $finish;
    end
  end
endmodule